// File: doc/BRIEF.md
# Second Alarm Power-Enable Controller

This block sits beside a calendar clock core. It holds a second alarm that covers the full date and time, and it drives a power-enable output toward an external power-management chip. Software loads six BCD alarm fields, arms a power-handover bit in a 32-bit power control register, and enables the second-alarm interrupt. The clock core reports the current BCD time together with a one-cycle strobe on each seconds update.

When the strobe arrives with the time equal to the alarm in every field, the block sets a sticky status flag. If the interrupt enable is set, the flag shows on the interrupt output. If both the handover bit and the interrupt enable are set, the power-enable output also drops to its off level and stays there. It returns to on only at reset or when software clears the handover bit. Debounce and the power sequencing itself lie outside this block.

Registers are 32 bits wide and written with a single-cycle write strobe. Read data follows the address combinationally. Addresses that no register decodes read as zero.

Top module: `alarm_pwr_ctl`

## Requirements
- R1: After a synchronous active-high reset, `pwr_en` is 1, `irq` is 0, and every register (alarm fields, status, interrupt enable, power control) reads 0.
- R2: Six 8-bit alarm fields sit at byte addresses 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (day), 0x90 (month) and 0x94 (year). Each stores `wdata[7:0]` and reads back zero-extended. Writes to any other address leave all six fields unchanged.
- R3: When `time_upd` is 1 and all six fields of `cur_time` equal the alarm, status bit 7 (address 0x44) reads 1 from the next clock edge on. A difference in any one field sets nothing. `cur_time` packs seconds in [7:0], minutes in [15:8], hours in [23:16], day in [31:24], month in [39:32] and year in [47:40].
- R4: A match is taken only on a cycle with `time_upd` high. A time that stays equal to the alarm without a strobe never sets the flag again after it has been cleared.
- R5: Writing 0x44 with bit 7 set clears the status flag. A write with bit 7 clear leaves it. A match in the same cycle as a clearing write leaves the flag set.
- R6: The interrupt-enable bit is bit 4 of address 0x48 and reads back there. `irq` equals status flag AND enable. Writing 0 to 0x48 clears the enable and drops `irq`.
- R7: The power control register at 0x98 stores only bit 16, the handover bit. All other bits read 0.
- R8: With bit 16 of 0x98 and bit 4 of 0x48 both set, a match drives `pwr_en` to 0 from the next clock edge.
- R9: With bit 16 clear, a match sets the flag and `irq` but leaves `pwr_en` at 1.
- R10: With bit 16 set but the interrupt enable clear, a match leaves `pwr_en` at 1.
- R11: Once low, `pwr_en` stays low through later updates, status clears and enable changes. It returns to 1 at the clock edge of a write of 0x98 with bit 16 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| time_upd | input | 1 | One-cycle strobe: the core has just updated the seconds |
| cur_time | input | 48 | Current BCD time from the clock core |
| irq | output | 1 | Second-alarm interrupt |
| pwr_en | output | 1 | Power-enable toward the power chip, 1 = on |

## Verification
The bench walks a match that misses in each single field in turn. A design that compared only some fields would raise the flag, or switch power off, on a near miss.

It holds the time equal to the alarm without a strobe after clearing the flag. A level-based detector would set the flag again at once. It also collides a clearing write with a match and expects the flag to survive.

Power gating is driven with the handover bit and the interrupt enable in each combination. A design that ignored either qualifier would drop `pwr_en` too early. One that failed to latch the off state, or to release it on clearing the handover bit, would show the wrong level in the later random rounds, where a bench model carries the power state across iterations.

// File: rtl/alarm_pwr_pkg.sv
package alarm_pwr_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int FIELD_W = 8;
    localparam int NFIELD  = 6;

    localparam logic [ADDR_W-1:0] ALM_BASE   = 8'h80;
    localparam logic [ADDR_W-1:0] ALM_STRIDE = 8'h04;
    localparam logic [ADDR_W-1:0] STAT_OFF   = 8'h44;
    localparam logic [ADDR_W-1:0] IE_OFF     = 8'h48;
    localparam logic [ADDR_W-1:0] CTL_OFF    = 8'h98;

    localparam int ST_BIT  = 7;
    localparam int IE_BIT  = 4;
    localparam int ARM_BIT = 16;

    typedef struct packed {
        logic ie;    // second-alarm interrupt enable
        logic arm;   // power handover to the alarm
        logic st;    // sticky match flag
        logic off;   // power-enable driven off
    } pwr_state_t;

    function automatic logic [ADDR_W-1:0] field_addr(input int idx);
        return ALM_BASE + ADDR_W'(idx) * ALM_STRIDE;
    endfunction

endpackage

// File: rtl/alarm_pwr_fields.sv
module alarm_pwr_fields
    import alarm_pwr_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int NF = NFIELD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [FW-1:0]        wbyte,
    output logic [NF*FW-1:0]     alarm,
    output logic [DATA_W-1:0]    rd_val
);
    localparam int ALM_W = NF * FW;

    logic [FW-1:0] fld [NF];
    logic [NF-1:0] sel;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        assign sel[i] = (addr == field_addr(i));
        always_ff @(posedge clk) begin
            if (rst)
                fld[i] <= '0;
            else if (wr_en && sel[i])
                fld[i] <= wbyte;
        end
        assign alarm[i*FW +: FW] = fld[i];
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NF; i++)
            if (sel[i])
                rd_val[FW-1:0] = fld[i];
    end

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || sel == '0) |=> $stable(alarm)) else $error("field changed"); // R2

    logic [ALM_W-1:0] unused_alm_w;
    assign unused_alm_w = alarm;
endmodule

// File: rtl/alarm_pwr_match.sv
module alarm_pwr_match
    import alarm_pwr_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int NF = NFIELD
) (
    input  logic             time_upd,
    input  logic [NF*FW-1:0] cur_time,
    input  logic [NF*FW-1:0] alarm,
    output logic             hit
);
    logic [NF-1:0] eq;

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        assign eq[i] = (cur_time[i*FW +: FW] == alarm[i*FW +: FW]);
    end

    assign hit = time_upd && (&eq);
endmodule

// File: rtl/alarm_pwr_state.sv
module alarm_pwr_state
    import alarm_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              w_st,
    input  logic              w_ie,
    input  logic              w_arm,
    input  logic              hit,
    output logic              irq,
    output logic              pwr_en,
    output logic [DATA_W-1:0] rd_val
);
    pwr_state_t q;
    logic st_wr, ie_wr, ctl_wr;

    assign st_wr  = wr_en && (addr == STAT_OFF);
    assign ie_wr  = wr_en && (addr == IE_OFF);
    assign ctl_wr = wr_en && (addr == CTL_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (ie_wr)
                q.ie <= w_ie;
            if (ctl_wr)
                q.arm <= w_arm;
            if (hit)
                q.st <= 1'b1;
            else if (st_wr && w_st)
                q.st <= 1'b0;
            if (hit && q.arm && q.ie)
                q.off <= 1'b1;
            else if (ctl_wr && !w_arm)
                q.off <= 1'b0;
        end
    end

    assign irq    = q.st && q.ie;
    assign pwr_en = !q.off;

    always_comb begin
        rd_val = '0;
        if (addr == STAT_OFF) rd_val[ST_BIT]  = q.st;
        if (addr == IE_OFF)   rd_val[IE_BIT]  = q.ie;
        if (addr == CTL_OFF)  rd_val[ARM_BIT] = q.arm;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (q == '0)) else $error("reset state"); // R1
    AST_HIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        hit |=> q.st) else $error("match lost"); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (st_wr && w_st && !hit) |=> !q.st) else $error("flag not cleared"); // R5
    AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(q.off) |-> $past(hit && q.ie && q.arm)) else $error("off without cause"); // R8
    AST_OFF_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        q.off |-> q.arm) else $error("off while unarmed"); // R11
    AST_OFF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (q.off && !(ctl_wr && !w_arm)) |=> q.off) else $error("off released"); // R11
endmodule

// File: rtl/alarm_pwr_ctl.sv
module alarm_pwr_ctl
    import alarm_pwr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic                      time_upd,
    input  logic [NFIELD*FIELD_W-1:0] cur_time,
    output logic                      irq,
    output logic                      pwr_en
);
    localparam int ALM_W = NFIELD * FIELD_W;

    logic [ALM_W-1:0]  alarm;
    logic [DATA_W-1:0] fld_rd, st_rd;
    logic              hit;

    alarm_pwr_fields #(.FW(FIELD_W), .NF(NFIELD)) u_fields (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wbyte  (wdata[FIELD_W-1:0]),
        .alarm  (alarm),
        .rd_val (fld_rd)
    );

    alarm_pwr_match #(.FW(FIELD_W), .NF(NFIELD)) u_match (
        .time_upd (time_upd),
        .cur_time (cur_time),
        .alarm    (alarm),
        .hit      (hit)
    );

    alarm_pwr_state u_state (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .w_st   (wdata[ST_BIT]),
        .w_ie   (wdata[IE_BIT]),
        .w_arm  (wdata[ARM_BIT]),
        .hit    (hit),
        .irq    (irq),
        .pwr_en (pwr_en),
        .rd_val (st_rd)
    );

    assign rdata = fld_rd | st_rd;

    logic unused_wdata;
    assign unused_wdata = ^wdata;
endmodule

// File: tb/tb_alarm_pwr_ctl.sv
module tb_alarm_pwr_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        time_upd = 1'b0;
    logic [47:0] cur_time = '0;
    logic        irq, pwr_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_pwr_ctl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .time_upd(time_upd), .cur_time(cur_time),
        .irq(irq), .pwr_en(pwr_en)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] faddr(input int i);
        return 8'h80 + 8'(4 * i);
    endfunction

    function automatic logic exp_off_next(input logic off, input logic arm,
                                          input logic ie, input logic hit);
        return arm ? (off || (hit && ie)) : 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic tick(input logic [47:0] t);
        @(negedge clk);
        cur_time = t; time_upd = 1'b1;
        @(negedge clk);
        time_upd = 1'b0;
    endtask

    task automatic load_alarm(input logic [47:0] t);
        for (int i = 0; i < 6; i++) wr(faddr(i), {24'hFFFFFF, t[i*8 +: 8]});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R0 watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [47:0] alm, t;
        logic ie, arm, off, hit;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pwr_en", {31'd0, pwr_en}, 32'd1);
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 6; i++) begin rd(faddr(i), v); check("R1 field", v, 0); end
        rd(8'h44, v); check("R1 status", v, 0);
        rd(8'h48, v); check("R1 ie", v, 0);
        rd(8'h98, v); check("R1 ctl", v, 0);

        // R2 field storage
        alm = {to_bcd(25), to_bcd(12), to_bcd(31), to_bcd(23), to_bcd(59), to_bcd(58)};
        load_alarm(alm);
        for (int i = 0; i < 6; i++) begin
            rd(faddr(i), v); check("R2 readback", v, {24'd0, alm[i*8 +: 8]});
        end
        wr(8'h9C, 32'h000000AA);
        wr(8'h7C, 32'h000000AA);
        for (int i = 0; i < 6; i++) begin
            rd(faddr(i), v); check("R2 stray write", v, {24'd0, alm[i*8 +: 8]});
        end

        // R7 control storage
        wr(8'h98, 32'hFFFFFFFF);
        rd(8'h98, v); check("R7 ctl bits", v, 32'h00010000);
        wr(8'h98, 32'h0);

        // R3 single-field misses, then full match
        for (int i = 0; i < 6; i++) begin
            t = alm; t[i*8 +: 8] = t[i*8 +: 8] ^ 8'h01;
            tick(t);
            rd(8'h44, v); check("R3 near miss", v, 0);
        end
        tick(alm);
        rd(8'h44, v); check("R3 match flag", v, 32'h80);

        // R5 W1C
        wr(8'h44, 32'h7F);
        rd(8'h44, v); check("R5 zero write keeps", v, 32'h80);
        wr(8'h44, 32'h80);
        rd(8'h44, v); check("R5 clear", v, 0);

        // R4 no strobe, time still equal
        cur_time = alm;
        repeat (4) @(negedge clk);
        rd(8'h44, v); check("R4 no strobe", v, 0);

        // R5 set wins over simultaneous clear
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h44; wdata = 32'h80; cur_time = alm; time_upd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; time_upd = 1'b0;
        rd(8'h44, v); check("R5 set wins", v, 32'h80);

        // R6 irq gating
        check("R6 irq disabled", {31'd0, irq}, 0);
        wr(8'h48, 32'hFFFFFFFF);
        rd(8'h48, v); check("R6 ie readback", v, 32'h10);
        check("R6 irq enabled", {31'd0, irq}, 1);
        wr(8'h48, 32'h0);
        rd(8'h48, v); check("R6 ie cleared", v, 0);
        check("R6 irq dropped", {31'd0, irq}, 0);
        wr(8'h44, 32'h80);

        // R9 handover clear
        wr(8'h48, 32'h10);
        tick(alm);
        check("R9 irq", {31'd0, irq}, 1);
        check("R9 pwr_en", {31'd0, pwr_en}, 1);
        wr(8'h44, 32'h80);

        // R10 armed, interrupt disabled
        wr(8'h48, 32'h0);
        wr(8'h98, 32'h00010000);
        tick(alm);
        check("R10 pwr_en", {31'd0, pwr_en}, 1);
        wr(8'h44, 32'h80);

        // R8 armed and enabled
        wr(8'h48, 32'h10);
        tick(alm);
        check("R8 pwr_en off", {31'd0, pwr_en}, 0);

        // R11 sticky then release
        wr(8'h44, 32'h80);
        t = alm; t[7:0] = t[7:0] ^ 8'h01;
        tick(t);
        wr(8'h48, 32'h0);
        wr(8'h98, 32'hFFFFFFFF);
        check("R11 sticky", {31'd0, pwr_en}, 0);
        wr(8'h98, 32'hFFFEFFFF);
        check("R11 release", {31'd0, pwr_en}, 1);

        // Random rounds against a bench model
        off = 1'b0;
        for (int n = 0; n < 150; n++) begin
            alm = {to_bcd($urandom_range(0, 99)), to_bcd($urandom_range(1, 12)),
                   to_bcd($urandom_range(1, 28)), to_bcd($urandom_range(0, 23)),
                   to_bcd($urandom_range(0, 59)), to_bcd($urandom_range(0, 59))};
            load_alarm(alm);
            ie  = 1'($urandom_range(0, 1));
            arm = 1'($urandom_range(0, 1));
            wr(8'h48, {27'd0, ie, 4'd0});
            wr(8'h98, {15'd0, arm, 16'd0});
            off = exp_off_next(off, arm, 1'b0, 1'b0);
            wr(8'h44, 32'h80);
            t = alm;
            hit = 1'b1;
            if ($urandom_range(0, 1) == 0) begin
                int k;
                k = $urandom_range(0, 5);
                t[k*8 +: 8] = t[k*8 +: 8] ^ 8'h10;
                hit = 1'b0;
            end
            tick(t);
            off = exp_off_next(off, arm, ie, hit);
            rd(8'h44, v); check("R3 random flag", v, {24'd0, hit, 7'd0});
            check("R6 random irq", {31'd0, irq}, {31'd0, hit && ie});
            check("R8 random pwr_en", {31'd0, pwr_en}, {31'd0, !off});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule